// File: doc/BRIEF.md
# Stop Mode Sequencer

This block decides when a processor core may drop into a deep stop state and when it must come back. The core signals a stop request in one of three ways: a wait-for-interrupt strobe, a wait-for-event strobe, or a return-from-handler strobe while sleep-on-exit is set. The request is taken only when deep sleep is enabled and nothing is pending. A 3-bit mode select picks the stop variant, and the block drives the main and low-power regulator enables to match.

When a stop is accepted, the block latches three things: the path that caused it, the wake-source rule that follows from that path and the send-event-on-pending option, and the run flavour to return to. It then watches the per-line interrupt and event pending vectors under that rule. On a wake, it holds a wake state until the oscillator-ready and memory-ready handshakes are both high, and then it returns the core to normal run or low-power run.

Top module: `lp_stop_ctrl`

## Requirements
- R1: During and after reset, `state_o` is 0 (normal run), `main_reg_en_o` is 1, `lp_reg_en_o` is 0 and `wake_tgt_o` is 0.
- R2: A `wfi_i` or `wfe_i` pulse in a run state starts a stop on the same clock edge, but only while `deep_en_i` is 1. With `deep_en_i` at 0 the pulse is ignored.
- R3: An `isr_ret_i` pulse starts a stop only when `sleep_on_exit_i` and `deep_en_i` are both 1. It then behaves as the interrupt path.
- R4: A request is refused and the state stays in run if any bit of `irq_pend_i`, `evt_pend_i` or `periph_wake_i` is set on that edge.
- R5: `mode_sel_i` = 000 enters state 2 (light stop), with the main regulator on and the low-power regulator off.
- R6: `mode_sel_i` = 001 enters state 3 (awaiting the low-power regulator), with both regulators on. The block moves to state 4 (regulator stop, main off, low-power on) on the first edge where `lpreg_rdy_i` is 1. Entry is allowed from normal run and from low-power run.
- R7: `mode_sel_i` above 001 enters state 5 (deepest variant), with the main regulator off and the low-power regulator on.
- R8: After an interrupt-path entry, only a line with both `irq_pend_i` and `irq_en_i` set wakes the core. Event pending bits and disabled interrupt lines do not.
- R9: After a wait-for-event entry with `sev_on_pend_i` = 0, only `evt_pend_i` bits wake the core. Interrupt pending bits do not.
- R10: After a wait-for-event entry with `sev_on_pend_i` = 1, any `irq_pend_i` bit wakes the core whether or not it is enabled. Event pending bits do not.
- R11: A wake moves the block to state 6, where both regulators are on. It stays there until `osc_rdy_i` and `mem_rdy_i` are both 1 on the same edge.
- R12: The value of `lp_run_sel_i` at entry is latched and shown on `wake_tgt_o`. On exit, the state becomes 1 (low-power run, main off, low-power on) if that value is 1, and 0 otherwise.
- R13: The wake rule is fixed at entry. Changing `sev_on_pend_i` during a stop does not change which sources wake the core.
- R14: A valid wake source seen in state 3 aborts the entry and moves the block straight to state 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wfi_i | input | 1 | Wait-for-interrupt request strobe |
| wfe_i | input | 1 | Wait-for-event request strobe |
| isr_ret_i | input | 1 | Return-from-handler strobe |
| deep_en_i | input | 1 | Deep-sleep enable |
| sleep_on_exit_i | input | 1 | Stop on return from handler |
| mode_sel_i | input | 3 | Stop variant select |
| lp_run_sel_i | input | 1 | Return to low-power run on exit |
| sev_on_pend_i | input | 1 | Pending interrupts count as events |
| irq_pend_i | input | N_LINES | Per-line interrupt pending |
| irq_en_i | input | N_LINES | Per-line interrupt vector enable |
| evt_pend_i | input | N_LINES | Per-line event pending |
| periph_wake_i | input | N_LINES | Peripheral wakeup flags |
| lpreg_rdy_i | input | 1 | Low-power regulator ready |
| osc_rdy_i | input | 1 | Oscillator ready |
| mem_rdy_i | input | 1 | Memory ready |
| main_reg_en_o | output | 1 | Main regulator enable |
| lp_reg_en_o | output | 1 | Low-power regulator enable |
| state_o | output | 3 | Current power state code |
| wake_tgt_o | output | 1 | Latched exit target (1 = low-power run) |

## Verification
Every state change shows on `state_o` and the regulator enables one edge after the inputs that caused it, so a wrong next-state choice is visible within a cycle. A wrong latched wake rule or exit target stays hidden during the stop. It appears only when a wake source arrives that the correct rule would treat differently, or at the exit edge. For this reason the bench offers sources that the rule must reject before it offers the one the rule must accept.

// File: rtl/lp_stop_pkg.sv
package lp_stop_pkg;
  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_LPRUN  = 3'd1,
    PS_STOP0  = 3'd2,
    PS_ENTER1 = 3'd3,
    PS_STOP1  = 3'd4,
    PS_DEEP   = 3'd5,
    PS_WAKE   = 3'd6
  } pstate_e;

  typedef enum logic [1:0] {
    WR_IRQ_EN  = 2'd0,
    WR_EVT     = 2'd1,
    WR_IRQ_ANY = 2'd2
  } wrule_e;

  localparam int unsigned MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_LIGHT = 3'd0;
  localparam logic [MODE_W-1:0] MODE_LPREG = 3'd1;
endpackage

// File: rtl/lp_stop_entry.sv
module lp_stop_entry
  import lp_stop_pkg::*;
#(
  parameter int unsigned N_LINES = 16
) (
  input  logic               wfi_i,
  input  logic               wfe_i,
  input  logic               isr_ret_i,
  input  logic               deep_en_i,
  input  logic               sleep_on_exit_i,
  input  logic               sev_on_pend_i,
  input  logic [N_LINES-1:0] irq_pend_i,
  input  logic [N_LINES-1:0] evt_pend_i,
  input  logic [N_LINES-1:0] periph_wake_i,
  output logic               go_o,
  output wrule_e             rule_o
);
  logic irq_path, req, blocked;

  always_comb begin
    irq_path = wfi_i | (isr_ret_i & sleep_on_exit_i);
    req      = deep_en_i & (irq_path | wfe_i);
    blocked  = (|irq_pend_i) | (|evt_pend_i) | (|periph_wake_i);
    go_o     = req & ~blocked;
    // interrupt path wins if both strobes arrive together
    if (irq_path)           rule_o = WR_IRQ_EN;
    else if (sev_on_pend_i) rule_o = WR_IRQ_ANY;
    else                    rule_o = WR_EVT;
  end
endmodule

// File: rtl/lp_stop_wake.sv
module lp_stop_wake
  import lp_stop_pkg::*;
#(
  parameter int unsigned N_LINES = 16
) (
  input  wrule_e             rule_i,
  input  logic [N_LINES-1:0] irq_pend_i,
  input  logic [N_LINES-1:0] irq_en_i,
  input  logic [N_LINES-1:0] evt_pend_i,
  output logic               hit_o
);
  logic [N_LINES-1:0] line_hit;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    always_comb begin
      unique case (rule_i)
        WR_IRQ_EN:  line_hit[i] = irq_pend_i[i] & irq_en_i[i];
        WR_EVT:     line_hit[i] = evt_pend_i[i];
        WR_IRQ_ANY: line_hit[i] = irq_pend_i[i];
        default:    line_hit[i] = 1'b0;
      endcase
    end
  end

  assign hit_o = |line_hit;
endmodule

// File: rtl/lp_stop_ctrl.sv
module lp_stop_ctrl
  import lp_stop_pkg::*;
#(
  parameter int unsigned N_LINES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wfi_i,
  input  logic               wfe_i,
  input  logic               isr_ret_i,
  input  logic               deep_en_i,
  input  logic               sleep_on_exit_i,
  input  logic [2:0]         mode_sel_i,
  input  logic               lp_run_sel_i,
  input  logic               sev_on_pend_i,
  input  logic [N_LINES-1:0] irq_pend_i,
  input  logic [N_LINES-1:0] irq_en_i,
  input  logic [N_LINES-1:0] evt_pend_i,
  input  logic [N_LINES-1:0] periph_wake_i,
  input  logic               lpreg_rdy_i,
  input  logic               osc_rdy_i,
  input  logic               mem_rdy_i,
  output logic               main_reg_en_o,
  output logic               lp_reg_en_o,
  output logic [2:0]         state_o,
  output logic               wake_tgt_o
);
  pstate_e state_q, state_d;
  wrule_e  rule_q, rule_d, entry_rule;
  logic    tgt_q, tgt_d;
  logic    go, wake_hit, in_run, stopped, clk_ok;

  lp_stop_entry #(.N_LINES(N_LINES)) u_entry (
    .wfi_i          (wfi_i),
    .wfe_i          (wfe_i),
    .isr_ret_i      (isr_ret_i),
    .deep_en_i      (deep_en_i),
    .sleep_on_exit_i(sleep_on_exit_i),
    .sev_on_pend_i  (sev_on_pend_i),
    .irq_pend_i     (irq_pend_i),
    .evt_pend_i     (evt_pend_i),
    .periph_wake_i  (periph_wake_i),
    .go_o           (go),
    .rule_o         (entry_rule)
  );

  lp_stop_wake #(.N_LINES(N_LINES)) u_wake (
    .rule_i    (rule_q),
    .irq_pend_i(irq_pend_i),
    .irq_en_i  (irq_en_i),
    .evt_pend_i(evt_pend_i),
    .hit_o     (wake_hit)
  );

  assign in_run  = (state_q == PS_RUN) || (state_q == PS_LPRUN);
  assign stopped = (state_q == PS_ENTER1) || (state_q == PS_STOP0) ||
                   (state_q == PS_STOP1)  || (state_q == PS_DEEP);
  assign clk_ok  = osc_rdy_i & mem_rdy_i;

  always_comb begin
    state_d = state_q;
    rule_d  = rule_q;
    tgt_d   = tgt_q;
    unique case (state_q)
      PS_RUN, PS_LPRUN: begin
        if (go) begin
          rule_d = entry_rule;
          tgt_d  = lp_run_sel_i;
          if (mode_sel_i == MODE_LIGHT)      state_d = PS_STOP0;
          else if (mode_sel_i == MODE_LPREG) state_d = PS_ENTER1;
          else                               state_d = PS_DEEP;
        end
      end
      PS_ENTER1: begin
        if (wake_hit)         state_d = PS_WAKE;
        else if (lpreg_rdy_i) state_d = PS_STOP1;
      end
      PS_STOP0, PS_STOP1, PS_DEEP: begin
        if (wake_hit) state_d = PS_WAKE;
      end
      PS_WAKE: begin
        if (clk_ok) state_d = tgt_q ? PS_LPRUN : PS_RUN;
      end
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_RUN;
      rule_q  <= WR_IRQ_EN;
      tgt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rule_q  <= rule_d;
      tgt_q   <= tgt_d;
    end
  end

  always_comb begin
    unique case (state_q)
      PS_RUN, PS_STOP0:   {main_reg_en_o, lp_reg_en_o} = 2'b10;
      PS_LPRUN, PS_STOP1,
      PS_DEEP:            {main_reg_en_o, lp_reg_en_o} = 2'b01;
      PS_ENTER1, PS_WAKE: {main_reg_en_o, lp_reg_en_o} = 2'b11;
      default:            {main_reg_en_o, lp_reg_en_o} = 2'b10;
    endcase
  end

  assign state_o    = state_q;
  assign wake_tgt_o = tgt_q;

  assert_nodeep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_run && !deep_en_i) |=> (state_q == $past(state_q)));

  assert_refuse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_run && ((|irq_pend_i) || (|evt_pend_i) || (|periph_wake_i)))
      |=> (state_q == $past(state_q)));

  assert_lpreg_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_ENTER1 && !lpreg_rdy_i && !wake_hit) |=> (state_q == PS_ENTER1));

  assert_stop1_regs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_STOP1) |-> (!main_reg_en_o && lp_reg_en_o));

  assert_wake_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_WAKE && !clk_ok) |=> (state_q == PS_WAKE));

  assert_exit_tgt_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_WAKE && clk_ok)
      |=> (state_o == ($past(wake_tgt_o) ? 3'd1 : 3'd0)));

  assert_rule_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped && $past(stopped)) |-> ($stable(rule_q) && $stable(tgt_q)));
endmodule

// File: tb/sim_lp_stop_ctrl.sv
`timescale 1ns/1ps
module sim_lp_stop_ctrl;
  localparam int N = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wfi = 0, wfe = 0, isr_ret = 0, deep_en = 1, soe = 0;
  logic [2:0] mode = 3'd0;
  logic lp_sel = 0, sev = 0;
  logic [N-1:0] irq_pend = '0, irq_en = '0, evt_pend = '0, periph = '0;
  logic lpreg = 0, osc = 0, mem = 0;
  logic main_en, lp_en, tgt;
  logic [2:0] st;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lp_stop_ctrl #(.N_LINES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wfi_i(wfi), .wfe_i(wfe), .isr_ret_i(isr_ret),
    .deep_en_i(deep_en), .sleep_on_exit_i(soe), .mode_sel_i(mode),
    .lp_run_sel_i(lp_sel), .sev_on_pend_i(sev), .irq_pend_i(irq_pend),
    .irq_en_i(irq_en), .evt_pend_i(evt_pend), .periph_wake_i(periph),
    .lpreg_rdy_i(lpreg), .osc_rdy_i(osc), .mem_rdy_i(mem),
    .main_reg_en_o(main_en), .lp_reg_en_o(lp_en), .state_o(st), .wake_tgt_o(tgt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clr;
    irq_pend = '0; evt_pend = '0; periph = '0; irq_en = '0;
  endtask

  task automatic pulse(input int kind);  // 0 wfi, 1 wfe, 2 isr return
    if (kind == 0) wfi = 1; else if (kind == 1) wfe = 1; else isr_ret = 1;
    tick;
    wfi = 0; wfe = 0; isr_ret = 0;
  endtask

  task automatic finish_wake(input string tag, input int exp_st);
    clr;
    osc = 1; mem = 1; tick;
    chk(tag, st, exp_st);
    osc = 0; mem = 0;
  endtask

  task automatic t_reset;
    chk("R1 state in reset", st, 0);
    chk("R1 main in reset", main_en, 1);
    chk("R1 lp in reset", lp_en, 0);
    rst_ni = 1; tick;
    chk("R1 state after reset", st, 0);
    chk("R1 tgt after reset", tgt, 0);
  endtask

  task automatic t_nodeep;
    deep_en = 0; pulse(0);
    chk("R2 wfi without deep ignored", st, 0);
    pulse(1);
    chk("R2 wfe without deep ignored", st, 0);
    deep_en = 1;
  endtask

  task automatic t_isr;
    soe = 0; pulse(2);
    chk("R3 isr ret without sleep-on-exit", st, 0);
    soe = 1; pulse(2);
    chk("R3 isr ret enters stop", st, 2);
    soe = 0;
    evt_pend[3] = 1; tick;
    chk("R3 interrupt path ignores event", st, 2);
    evt_pend = '0; irq_pend[2] = 1; irq_en[2] = 1; tick;
    chk("R3 enabled irq wakes", st, 6);
    clr; osc = 1; tick;
    chk("R11 osc only holds wake", st, 6);
    osc = 0; mem = 1; tick;
    chk("R11 mem only holds wake", st, 6);
    chk("R11 wake regs main", main_en, 1);
    chk("R11 wake regs lp", lp_en, 1);
    mem = 0;
    finish_wake("R11 both ready exits to run", 0);
  endtask

  task automatic t_refuse;
    evt_pend[1] = 1; pulse(0);
    chk("R4 event pending refuses", st, 0);
    clr; periph[0] = 1; pulse(1);
    chk("R4 peripheral flag refuses", st, 0);
    clr; irq_pend[N-1] = 1; pulse(0);
    chk("R4 irq pending refuses", st, 0);
    clr;
  endtask

  task automatic t_light;
    mode = 3'd0; pulse(0);
    chk("R5 light stop state", st, 2);
    chk("R5 main on", main_en, 1);
    chk("R5 lp off", lp_en, 0);
    evt_pend[0] = 1; tick;
    chk("R8 event ignored after wfi", st, 2);
    evt_pend = '0; irq_pend[4] = 1; tick;
    chk("R8 disabled irq ignored", st, 2);
    irq_en[4] = 1; tick;
    chk("R8 enabled irq wakes", st, 6);
    finish_wake("R8 exit", 0);
  endtask

  task automatic t_lpreg;
    mode = 3'd1; lpreg = 0; pulse(0);
    chk("R6 waits for lp regulator", st, 3);
    chk("R6 both regs on main", main_en, 1);
    chk("R6 both regs on lp", lp_en, 1);
    tick;
    chk("R6 still waiting", st, 3);
    lpreg = 1; tick;
    chk("R6 regulator stop", st, 4);
    chk("R6 main off", main_en, 0);
    chk("R6 lp on", lp_en, 1);
    irq_pend[7] = 1; irq_en[7] = 1; tick;
    chk("R6 wake from regulator stop", st, 6);
    finish_wake("R6 exit", 0);
    lpreg = 0;
  endtask

  task automatic t_deep;
    mode = 3'd3; pulse(0);
    chk("R7 deepest variant", st, 5);
    chk("R7 main off", main_en, 0);
    chk("R7 lp on", lp_en, 1);
    irq_pend[1] = 1; irq_en[1] = 1; tick;
    chk("R7 wake", st, 6);
    finish_wake("R7 exit", 0);
    mode = 3'd0;
  endtask

  task automatic t_evt0;
    sev = 0; pulse(1);
    chk("R9 wfe entry", st, 2);
    irq_pend = '1; irq_en = '1; tick;
    chk("R9 irq ignored", st, 2);
    clr; evt_pend[9] = 1; tick;
    chk("R9 event wakes", st, 6);
    finish_wake("R9 exit", 0);
  endtask

  task automatic t_evt1;
    sev = 1; pulse(1);
    chk("R10 wfe entry", st, 2);
    evt_pend[2] = 1; tick;
    chk("R10 event ignored", st, 2);
    evt_pend = '0; irq_pend[5] = 1; tick;
    chk("R10 disabled irq wakes", st, 6);
    finish_wake("R10 exit", 0);
    sev = 0;
  endtask

  task automatic t_latch;
    sev = 1; pulse(1);
    sev = 0; evt_pend[6] = 1; tick;
    chk("R13 rule kept despite option change", st, 2);
    evt_pend = '0; irq_pend[6] = 1; tick;
    chk("R13 original rule wakes", st, 6);
    finish_wake("R13 exit", 0);
  endtask

  task automatic t_lprun;
    lp_sel = 1; pulse(0);
    lp_sel = 0;
    chk("R12 target latched", tgt, 1);
    irq_pend[0] = 1; irq_en[0] = 1; tick;
    finish_wake("R12 exit to low-power run", 1);
    chk("R12 lprun main off", main_en, 0);
    chk("R12 lprun lp on", lp_en, 1);
    mode = 3'd1; lpreg = 1; pulse(0);
    chk("R6 entry from low-power run", st, 3);
    tick;
    chk("R6 regulator stop from lprun", st, 4);
    chk("R12 new target", tgt, 0);
    irq_pend[0] = 1; irq_en[0] = 1; tick;
    finish_wake("R12 exit to run", 0);
    lpreg = 0; mode = 3'd0;
  endtask

  task automatic t_abort;
    mode = 3'd1; lpreg = 0; pulse(0);
    chk("R14 waiting", st, 3);
    irq_pend[3] = 1; irq_en[3] = 1; tick;
    chk("R14 abort to wake", st, 6);
    finish_wake("R14 exit", 0);
    mode = 3'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_nodeep;
    t_isr;
    t_refuse;
    t_light;
    t_lpreg;
    t_deep;
    t_evt0;
    t_evt1;
    t_latch;
    t_lprun;
    t_abort;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule